// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block prepares a DRAM for use and keeps it refreshed. After reset it holds the memory idle for a fixed settling pause. It then runs a burst of wake-up refresh cycles. Once the burst is done it opens the memory to the host side. From then on it counts refresh intervals so that every row is refreshed within the retention window, whether the part has 2K rows and a 32 ms window or 4K rows and a 64 ms window.

Each refresh is offered to the access controller through a request/grant pair. Once the refresh is granted, the block drives the strobe pins itself. It generates a column-strobe-first refresh, so the row address comes from the memory's internal counter and no address is driven. The controller may hold off grants, for example during a long page burst. The block keeps a saturating count of refreshes owed and flags urgency when that count grows too large. If the count is already full when another interval expires, the retention deadline has been missed. The block then withdraws readiness and repeats the whole wake-up burst.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset release, ref_req, ras_n low and cas_n low all stay inactive for exactly PAUSE_CYC clock edges. ref_req rises after edge PAUSE_CYC.
- R2: After the pause, exactly WAKE_CNT refresh cycles are requested and executed while init_done is 0. init_done rises only after the last of them has finished its precharge.
- R3: Each granted refresh drives cas_n low for CSR_CYC cycles with ras_n high. Both strobes are then low for RAS_CYC cycles and rise together. Both then stay high for at least RP_CYC cycles. ras_n is never low while cas_n is high.
- R4: With grants always given in normal operation, consecutive refresh cycles start exactly REF_INT_CYC cycles apart.
- R5: While grants are withheld, each expired interval adds one owed refresh and starts no cycle. A later grant stream executes one cycle per owed refresh, and ref_req then falls.
- R6: urgent is 1 exactly while the owed count is at least URGENT_THR, and it is 0 when nothing is owed.
- R7: If an interval expires while OWED_MAX refreshes are already owed, init_done falls, the owed count clears (urgent 0), and the WAKE_CNT-cycle wake burst is repeated before init_done rises again.
- R8: host_ok equals host_req while init_done is 1 and is 0 otherwise.
- R9: An interval expiry and a grant in the same cycle leave the owed count unchanged: one owed refresh is added and one is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Access controller grants the pending refresh |
| host_req | input | 1 | Host access request to be gated |
| ref_req | output | 1 | A refresh cycle is pending and the strobe generator is idle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| init_done | output | 1 | Wake-up complete, memory usable |
| urgent | output | 1 | Owed refreshes at or above the threshold |
| host_ok | output | 1 | host_req passed through once the memory is ready |

## Verification
The interval tick and a refresh grant can land on the same clock edge. This moves the owed counter both up and down at once. The bench withholds grants until urgent rises, which marks the edge of a tick, and then turns the grant on for exactly the edge one interval later. The collision is judged twice: urgent must still be high on the following cycle, and the drain that follows must contain the threshold count plus one refresh cycles.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_MHZ     = 200,
  parameter bit REFRESH_4K  = 1'b0,
  parameter int PAUSE_CYC   = CLK_MHZ * 200,
  parameter int WAKE_CNT    = 8,
  parameter int REF_INT_CYC = REFRESH_4K ? (CLK_MHZ * 64000 / 4096) : (CLK_MHZ * 32000 / 2048),
  parameter int OWED_MAX    = 8,
  parameter int URGENT_THR  = 4,
  parameter int CSR_CYC     = 2,
  parameter int RAS_CYC     = 10,
  parameter int RP_CYC      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic host_req,
  output logic ref_req,
  output logic ras_n,
  output logic cas_n,
  output logic init_done,
  output logic urgent,
  output logic host_ok
);
  localparam int PW   = $clog2(PAUSE_CYC + 1);
  localparam int IW   = $clog2(REF_INT_CYC + 1);
  localparam int OW   = $clog2(OWED_MAX + 1);
  localparam int WW   = $clog2(WAKE_CNT + 1);
  localparam int SM1  = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int SMAX = (SM1 > RP_CYC) ? SM1 : RP_CYC;
  localparam int SW   = $clog2(SMAX + 1);

  typedef enum logic [1:0] {ST_PAUSE, ST_WAKE, ST_RUN} st_t;
  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_ACT, PH_PRE} ph_t;

  st_t         state;
  ph_t         ph;
  logic [PW-1:0] pcnt;
  logic [IW-1:0] icnt;
  logic [OW-1:0] owed;
  logic [WW-1:0] wake_left;
  logic [SW-1:0] scnt;

  logic pending, grant, tick, miss;

  assign pending   = (state == ST_WAKE && wake_left != '0) || (state == ST_RUN && owed != '0);
  assign ref_req   = pending && ph == PH_IDLE;
  assign grant     = ref_req && ref_gnt;
  assign tick      = state == ST_RUN && icnt == IW'(REF_INT_CYC - 1);
  assign miss      = tick && owed == OW'(OWED_MAX);
  assign cas_n     = !(ph == PH_LEAD || ph == PH_ACT);
  assign ras_n     = !(ph == PH_ACT);
  assign init_done = state == ST_RUN;
  assign urgent    = owed >= OW'(URGENT_THR);
  assign host_ok   = host_req && init_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      scnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (grant) begin ph <= PH_LEAD; scnt <= '0; end
        PH_LEAD: if (scnt == SW'(CSR_CYC - 1)) begin ph <= PH_ACT; scnt <= '0; end
                 else scnt <= scnt + 1'b1;
        PH_ACT:  if (scnt == SW'(RAS_CYC - 1)) begin ph <= PH_PRE; scnt <= '0; end
                 else scnt <= scnt + 1'b1;
        default: if (scnt == SW'(RP_CYC - 1)) begin ph <= PH_IDLE; scnt <= '0; end
                 else scnt <= scnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_PAUSE;
      pcnt      <= '0;
      icnt      <= '0;
      owed      <= '0;
      wake_left <= '0;
    end else begin
      case (state)
        ST_PAUSE: begin
          if (pcnt == PW'(PAUSE_CYC - 1)) begin
            state     <= ST_WAKE;
            wake_left <= WW'(WAKE_CNT);
          end else pcnt <= pcnt + 1'b1;
        end
        ST_WAKE: begin
          if (grant) wake_left <= wake_left - 1'b1;
          else if (wake_left == '0 && ph == PH_IDLE) begin
            state <= ST_RUN;
            icnt  <= '0;
          end
        end
        default: begin
          icnt <= tick ? '0 : icnt + 1'b1;
          if (miss) begin
            state     <= ST_WAKE;
            wake_left <= WW'(WAKE_CNT);
            owed      <= '0;
          end else if (tick && !grant) owed <= owed + 1'b1;
          else if (!tick && grant)     owed <= owed - 1'b1;
        end
      endcase
    end
  end

  p_quiet_pause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PAUSE |-> ras_n && cas_n && !ref_req);
  p_ras_under_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
  p_cas_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  p_grant_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !cas_n && ras_n && !ref_req);
  p_owed_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(OWED_MAX));
  p_urgent_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> init_done);
  p_miss_rewake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_done) |-> owed == '0 && wake_left == WW'(WAKE_CNT));
  p_collide_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && grant && !miss) |=> $stable(owed));
endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  localparam int PAUSE = 50, WAKE = 8, RINT = 200, OMAX = 6, THR = 4;
  localparam int CSR = 2, RASC = 10, RP = 6;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0, host_req = 1'b0;
  logic ref_req, ras_n, cas_n, init_done, urgent, host_ok;
  int checks = 0, errors = 0, cyc = 0;
  int falls = 0, fall_cyc = 0;
  int lead = 0, act = 0, pre = 1000;
  logic pras = 1'b1, pcas = 1'b1;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(.PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .REF_INT_CYC(RINT),
    .OWED_MAX(OMAX), .URGENT_THR(THR), .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP))
  u_dram_refresh_sched (.clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .host_req(host_req),
    .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .init_done(init_done),
    .urgent(urgent), .host_ok(host_ok));

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // R3 strobe shape monitor, sampled at negedge
  always @(negedge clk) if (rst_n) begin
    if (!ras_n && cas_n) chk(1'b0, "R3 ras low with cas high", 1, 0);
    if (pcas && !cas_n) begin
      falls++; fall_cyc = cyc; lead = 0;
      chk(pre >= RP, "R3 precharge", pre, RP);
    end
    if (!cas_n && ras_n) lead++;
    if (pras && !ras_n) begin chk(lead == CSR, "R3 cas lead", lead, CSR); act = 0; end
    if (!ras_n) act++;
    if (!pras && ras_n) begin
      chk(act == RASC, "R3 ras low width", act, RASC);
      chk(cas_n == 1'b1, "R3 strobes rise together", cas_n, 1);
      pre = 0;
    end
    if (ras_n && cas_n) pre++;
    pras = ras_n; pcas = cas_n;
  end

  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_pause();
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && !ref_req && !init_done && !urgent, "R1 reset state", ref_req, 0);
    rst_n = 1'b1;
    repeat (PAUSE - 1) @(negedge clk);
    chk(!ref_req && ras_n && cas_n, "R1 quiet through pause", ref_req, 0);
    @(negedge clk);
    chk(ref_req, "R1 request after pause", ref_req, 1);
  endtask

  task automatic t_wake();
    int base = falls;
    int n = 0;
    host_req = 1'b1;
    @(negedge clk);
    chk(!host_ok, "R8 host blocked during wake", host_ok, 0);
    ref_gnt = 1'b1;
    while (!init_done && n < 2000) begin @(negedge clk); n++; end
    chk(falls - base == WAKE, "R2 wake burst count", falls - base, WAKE);
    chk(pre >= RP && ras_n && cas_n, "R2 init after precharge", pre, RP);
    chk(host_ok, "R8 host passes when ready", host_ok, 1);
  endtask

  task automatic t_interval();
    int b = falls;
    int f1;
    while (falls == b) @(negedge clk);
    f1 = fall_cyc;
    @(negedge clk);
    chk(!ref_req, "R4 request drops after grant", ref_req, 0);
    b = falls;
    while (falls == b) @(negedge clk);
    chk(fall_cyc - f1 == RINT, "R4 interval", fall_cyc - f1, RINT);
  endtask

  task automatic t_owed_collide();
    int b, tu;
    int n = 0;
    @(negedge clk);
    ref_gnt = 1'b0;
    b = falls;
    while (!urgent && n < 3000) begin @(negedge clk); n++; end
    tu = cyc;
    chk(urgent, "R6 urgent rises", urgent, 1);
    chk(falls == b && ref_req, "R5 deferred with no cycles", falls - b, 0);
    while (cyc < tu + RINT - 1) @(negedge clk);
    b = falls;
    ref_gnt = 1'b1;
    @(negedge clk);
    chk(urgent, "R9 tick and grant keep owed", urgent, 1);
    repeat (RINT - 30) @(negedge clk);
    chk(falls - b == THR + 1, "R9 drain count", falls - b, THR + 1);
    chk(!ref_req, "R5 request falls when drained", ref_req, 0);
    chk(!urgent, "R6 urgent clears", urgent, 0);
  endtask

  task automatic t_miss();
    int b;
    int n = 0;
    @(negedge clk);
    ref_gnt = 1'b0;
    while (init_done && n < (OMAX + 3) * RINT) begin @(negedge clk); n++; end
    chk(!init_done, "R7 miss drops ready", init_done, 0);
    chk(!urgent, "R7 owed cleared", urgent, 0);
    chk(!host_ok, "R8 host blocked after miss", host_ok, 0);
    b = falls;
    ref_gnt = 1'b1;
    n = 0;
    while (!init_done && n < 2000) begin @(negedge clk); n++; end
    chk(falls - b == WAKE, "R7 wake repeated", falls - b, WAKE);
    host_req = 1'b0;
    @(negedge clk);
    chk(!host_ok && init_done, "R8 host follows request", host_ok, 0);
  endtask

  initial begin
    t_reset_pause();
    t_wake();
    t_interval();
    t_owed_collide();
    t_miss();
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule